// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and chooses which of five interrupt sources the core services next. The sources are an external pin that is edge-detected, two timer overflow requests, a combined external/miscellaneous request line, and a serial request formed from two serial units. Each source is qualified by its own enable bit and a global enable bit. A priority register places each source in a high or a low level. Within a level, a fixed order decides between simultaneous requests.

When a request wins, the block raises a request line toward the core and presents a fixed vector address. It holds both until the core acknowledges. On the acknowledge, the level of the accepted source is marked in service. A high-level request can interrupt a low-level handler. Nothing interrupts a high-level handler, and a request at the level already in service waits. A return-from-interrupt pulse ends the innermost service level.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The vector for each source is fixed: external pin 0x0003, timer A 0x000B, miscellaneous/external 0x0013, timer B 0x001B, serial 0x002B.
- R2: Within one priority level the winning source is the first pending one in the order: external pin, timer A, miscellaneous, timer B, serial.
- R3: A source can request only when its own enable bit and `en_reg[7]` are both 1. The own enable bits are `en_reg[0]`, `[1]`, `[2]`, `[3]` and `[5]` in the order of R2.
- R4: Priority bits `pri_reg[0]`, `[1]`, `[2]`, `[3]` and `[5]` (same order) put a source in the high level when 1. Any pending high-level source beats every low-level source.
- R5: The serial source is pending when either `ser_a_req` or `ser_b_req` is 1.
- R6: A falling edge on `ext0_pin_n`, seen through a two-stage synchronizer, sets an internal flag that requests the external-pin vector. The acknowledge of that vector clears the flag. A pin held low or a rising edge raises no further request.
- R7: With a low-level handler in service, only high-level sources can request. With a high-level handler in service, no source can request.
- R8: A one-cycle `reti` pulse ends the high-level service if it is active, and otherwise ends the low-level service.
- R9: Once `irq_req` rises, it and `irq_vec` stay unchanged until a cycle with `irq_ack` = 1. `irq_req` is 0 in the cycle after that acknowledge.
- R10: `en_reg[4]`, `en_reg[6]`, `pri_reg[4]`, `pri_reg[6]` and `pri_reg[7]` have no effect on requests.
- R11: After reset `irq_req` is 0, `irq_vec` is 0, and no level is in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_reg | input | 8 | Per-source enable bits plus global enable in bit 7 |
| pri_reg | input | 8 | Per-source level select, 1 = high |
| ext0_pin_n | input | 1 | Asynchronous external pin; falling edge requests |
| tmr0_req | input | 1 | Timer A overflow request (level) |
| misc_req | input | 1 | Combined miscellaneous/external request (level) |
| tmr1_req | input | 1 | Timer B overflow request (level) |
| ser_a_req | input | 1 | First serial unit request |
| ser_b_req | input | 1 | Second serial unit request |
| irq_ack | input | 1 | Core acknowledges the presented vector |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request toward the core |
| irq_vec | output | 16 | Vector address of the held request |

## Verification
The checker watches the request/acknowledge handshake on every cycle. It confirms that the vector is one of the five legal addresses while a request is up and stays stable until the acknowledge. It also confirms that the request drops after the acknowledge, that a cleared global enable or an active high-level service keeps the line low, and that a request raised during low-level service carries a high level. The bench scenarios must show which source wins under each mix of enables, levels and pending lines. They must also show that the external pin requests once per falling edge, that a return pulse pops the right level, and that a low request blocked during service reappears later.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   // number of arbitrated sources, fixed by the register layout
   localparam int NUM_SRC = 5;

   // source index in fixed order, highest first
   typedef enum logic [2:0] {
      SRC_EXT0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_MISC = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_SER  = 3'd4
   } src_e;

   // register bit and vector slot of a source: the last source skips slot 4
   function automatic int slot_of(input int idx);
      return (idx == NUM_SRC - 1) ? NUM_SRC : idx;
   endfunction

   typedef struct packed {
      logic hi;
      logic lo;
   } svc_t;

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic clr,
   output logic flag
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("irq_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;
   logic                   flag_q;
   logic                   fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], pin_n};
         prev_q  <= chain_q[SYNC_STAGES-1];
      end
   end

   assign fall = prev_q & ~chain_q[SYNC_STAGES-1];

   // a new edge wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= (flag_q & ~clr) | fall;
   end

   assign flag = flag_q;

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int N          = 5,
   parameter int VEC_W      = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8,
   parameter int ARB_STYLE  = 0,
   localparam int IDX_W     = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     pend,
   input  logic [N-1:0]     hi_mask,
   input  logic             svc_hi,
   input  logic             svc_lo,
   output logic             win_vld,
   output logic [IDX_W-1:0] win_idx,
   output logic             win_hi,
   output logic [VEC_W-1:0] win_vec
);
   import irq_vec_pkg::*;

   if (ARB_STYLE != 0 && ARB_STYLE != 1) begin : g_bad_style
      $error("irq_prio_arb: ARB_STYLE must be 0 or 1");
   end

   logic [VEC_W-1:0] vec_tab [N];

   for (genvar g = 0; g < N; g++) begin : g_vec
      localparam int SLOT = slot_of(g);
      assign vec_tab[g] = VEC_W'(VEC_BASE + SLOT * VEC_STRIDE);
   end

   logic [N-1:0] elig;
   logic [N-1:0] elig_hi;
   logic [N-1:0] pick;

   always_comb begin
      if (svc_hi)      elig = '0;
      else if (svc_lo) elig = pend & hi_mask;
      else             elig = pend;
      elig_hi = elig & hi_mask;
      pick    = (|elig_hi) ? elig_hi : elig;
   end

   assign win_vld = |pick;

   if (ARB_STYLE == 0) begin : g_scan
      always_comb begin
         win_idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (pick[i]) win_idx = IDX_W'(i);
         end
      end
   end else begin : g_onehot
      logic [N-1:0] lowest;
      assign lowest = pick & (~pick + N'(1));
      always_comb begin
         win_idx = '0;
         for (int i = 0; i < N; i++) begin
            if (lowest[i]) win_idx = win_idx | IDX_W'(i);
         end
      end
   end

   assign win_hi  = hi_mask[win_idx];
   assign win_vec = vec_tab[win_idx];

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic push_hi,
   input  logic pop,
   output logic svc_hi,
   output logic svc_lo
);
   import irq_vec_pkg::*;

   svc_t st_q;
   svc_t st_pop;
   svc_t st_d;

   always_comb begin
      // pop ends the innermost level first
      st_pop.hi = st_q.hi & ~pop;
      st_pop.lo = st_q.lo & ~(pop & ~st_q.hi);
      st_d      = st_pop;
      if (push) begin
         if (push_hi) st_d.hi = 1'b1;
         else         st_d.lo = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   assign svc_hi = st_q.hi;
   assign svc_lo = st_q.lo;

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
   parameter int REG_W       = 8,
   parameter int GLOBAL_BIT  = 7,
   parameter int VEC_W       = 16,
   parameter int VEC_BASE    = 3,
   parameter int VEC_STRIDE  = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ARB_STYLE   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] en_reg,
   input  logic [REG_W-1:0] pri_reg,
   input  logic             ext0_pin_n,
   input  logic             tmr0_req,
   input  logic             misc_req,
   input  logic             tmr1_req,
   input  logic             ser_a_req,
   input  logic             ser_b_req,
   input  logic             irq_ack,
   input  logic             reti,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec
);
   import irq_vec_pkg::*;

   localparam int N     = NUM_SRC;
   localparam int IDX_W = $clog2(N);
   localparam int TOP_V = VEC_BASE + slot_of(N - 1) * VEC_STRIDE;

   if (GLOBAL_BIT >= REG_W || GLOBAL_BIT <= slot_of(N - 1)) begin : g_bad_global
      $error("irq_vec_ctrl: GLOBAL_BIT must sit above all source bits and inside REG_W");
   end
   if (TOP_V >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_vec_ctrl: VEC_W too narrow for the vector table");
   end

   logic [N-1:0]     raw;
   logic [N-1:0]     pend;
   logic [N-1:0]     hi_mask;
   logic             ext0_flag;
   logic             ext0_clr;
   logic             svc_hi;
   logic             svc_lo;
   logic             win_vld;
   logic [IDX_W-1:0] win_idx;
   logic             win_hi;
   logic [VEC_W-1:0] win_vec;
   logic             req_q;
   logic [VEC_W-1:0] vec_q;
   logic [IDX_W-1:0] idx_q;
   logic             hi_q;
   logic             take;
   logic             unused_cfg;

   assign unused_cfg = ^{en_reg, pri_reg};

   irq_edge_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_ext0 (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_n(ext0_pin_n),
      .clr  (ext0_clr),
      .flag (ext0_flag)
   );

   assign raw = {ser_a_req | ser_b_req, tmr1_req, misc_req, tmr0_req, ext0_flag};

   for (genvar g = 0; g < N; g++) begin : g_qual
      localparam int BIT = slot_of(g);
      assign pend[g]    = raw[g] & en_reg[BIT] & en_reg[GLOBAL_BIT];
      assign hi_mask[g] = pri_reg[BIT];
   end

   irq_prio_arb #(
      .N         (N),
      .VEC_W     (VEC_W),
      .VEC_BASE  (VEC_BASE),
      .VEC_STRIDE(VEC_STRIDE),
      .ARB_STYLE (ARB_STYLE)
   ) u_arb (
      .pend   (pend),
      .hi_mask(hi_mask),
      .svc_hi (svc_hi),
      .svc_lo (svc_lo),
      .win_vld(win_vld),
      .win_idx(win_idx),
      .win_hi (win_hi),
      .win_vec(win_vec)
   );

   assign take     = req_q & irq_ack;
   assign ext0_clr = take & (idx_q == IDX_W'(SRC_EXT0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         vec_q <= '0;
         idx_q <= '0;
         hi_q  <= 1'b0;
      end else if (!req_q) begin
         if (win_vld) begin
            req_q <= 1'b1;
            vec_q <= win_vec;
            idx_q <= win_idx;
            hi_q  <= win_hi;
         end
      end else if (irq_ack) begin
         req_q <= 1'b0;
      end
   end

   irq_svc_track u_svc (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (take),
      .push_hi(hi_q),
      .pop    (reti),
      .svc_hi (svc_hi),
      .svc_lo (svc_lo)
   );

   assign irq_req = req_q;
   assign irq_vec = vec_q;

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
   parameter int VEC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       en_reg,
   input logic             irq_req,
   input logic [VEC_W-1:0] irq_vec,
   input logic             irq_ack,
   input logic             reti,
   input logic             svc_hi,
   input logic             svc_lo,
   input logic             req_hi
);

   AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec == VEC_W'(16'h0003) || irq_vec == VEC_W'(16'h000B) ||
                   irq_vec == VEC_W'(16'h0013) || irq_vec == VEC_W'(16'h001B) ||
                   irq_vec == VEC_W'(16'h002B)));                                     // R1

   AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_reg[7] && !irq_req) |=> !irq_req);                                        // R3

   AST_HI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_hi && !reti && !irq_req) |=> !irq_req);                                   // R7

   AST_LO_ONLY_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_lo && !svc_hi && !reti && !irq_req) |=> (!irq_req || req_hi));             // R7

   AST_HOLD_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));                      // R9

   AST_DROP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> !irq_req);                                            // R9

   AST_PUSH_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack && !reti) |=> (svc_hi || svc_lo));                          // R8

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en_reg (en_reg),
   .irq_req(irq_req),
   .irq_vec(irq_vec),
   .irq_ack(irq_ack),
   .reti   (reti),
   .svc_hi (svc_hi),
   .svc_lo (svc_lo),
   .req_hi (hi_q)
);

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int SEED       = 1234;
   localparam int WDOG       = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  en_reg = 8'h00;
   logic [7:0]  pri_reg = 8'h00;
   logic        ext0_pin_n = 1'b1;
   logic        tmr0_req = 1'b0;
   logic        misc_req = 1'b0;
   logic        tmr1_req = 1'b0;
   logic        ser_a_req = 1'b0;
   logic        ser_b_req = 1'b0;
   logic        irq_ack = 1'b0;
   logic        reti = 1'b0;
   logic        irq_req;
   logic [15:0] irq_vec;

   int checks = 0;
   int errors = 0;
   bit m_hi = 1'b0;
   bit m_lo = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_vec_ctrl u_irq_vec_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_reg    (en_reg),
      .pri_reg   (pri_reg),
      .ext0_pin_n(ext0_pin_n),
      .tmr0_req  (tmr0_req),
      .misc_req  (misc_req),
      .tmr1_req  (tmr1_req),
      .ser_a_req (ser_a_req),
      .ser_b_req (ser_b_req),
      .irq_ack   (irq_ack),
      .reti      (reti),
      .irq_req   (irq_req),
      .irq_vec   (irq_vec)
   );

   function automatic int slot(input int i);
      return (i == 4) ? 5 : i;
   endfunction

   function automatic logic [15:0] exp_vec(input int i);
      return 16'(3 + 8 * slot(i));
   endfunction

   // expected winner from R2, R3, R4, R5, R7; -1 when none
   function automatic int exp_idx(input logic [7:0] en, input logic [7:0] pri,
                                  input logic [4:0] rawv, input bit mh, input bit ml);
      logic [4:0] pend;
      logic [4:0] hm;
      logic [4:0] el;
      for (int i = 0; i < 5; i++) begin
         pend[i] = rawv[i] & en[slot(i)] & en[7];
         hm[i]   = pri[slot(i)];
      end
      if (mh)      el = '0;
      else if (ml) el = pend & hm;
      else         el = pend;
      if ((el & hm) != 0) el = el & hm;
      for (int i = 0; i < 5; i++) begin
         if (el[i]) return i;
      end
      return -1;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic clear_reqs();
      tmr0_req = 0; misc_req = 0; tmr1_req = 0; ser_a_req = 0; ser_b_req = 0;
   endtask

   task automatic wait_req(input int n, output bit got);
      got = 1'b0;
      for (int k = 0; k < n && !got; k++) begin
         @(negedge clk);
         if (irq_req) got = 1'b1;
      end
   endtask

   task automatic expect_vec(input logic [15:0] v, input string req);
      bit got;
      wait_req(8, got);
      check(got, req, {31'b0, got}, 32'd1);
      if (got) check(irq_vec == v, req, {16'b0, irq_vec}, {16'b0, v});
   endtask

   task automatic expect_quiet(input int n, input string req);
      bit seen = 1'b0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (irq_req) seen = 1'b1;
      end
      check(!seen, req, {31'b0, seen}, 32'd0);
   endtask

   task automatic do_ack(input bit lvl);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      if (lvl) m_hi = 1'b1; else m_lo = 1'b1;
   endtask

   task automatic do_reti();
      reti = 1'b1;
      @(negedge clk);
      reti = 1'b0;
      if (m_hi) m_hi = 1'b0; else m_lo = 1'b0;
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog R9: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(SEED);
      repeat (3) @(negedge clk);
      check(irq_req == 1'b0, "R11 req in reset", {31'b0, irq_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(irq_req == 1'b0 && irq_vec == 16'h0, "R11 after reset",
            {15'b0, irq_req, irq_vec}, 32'd0);

      // R6: external pin edge handling
      en_reg = 8'h81; pri_reg = 8'h00;
      @(negedge clk);
      ext0_pin_n = 1'b0;
      expect_vec(16'h0003, "R6 falling edge vector (R1)");
      do_ack(1'b0);
      do_reti();
      expect_quiet(8, "R6 pin held low no repeat");
      ext0_pin_n = 1'b1;
      expect_quiet(8, "R6 rising edge ignored");
      ext0_pin_n = 1'b0;
      expect_vec(16'h0003, "R6 second falling edge");
      do_ack(1'b0);
      do_reti();
      ext0_pin_n = 1'b1;
      repeat (4) @(negedge clk);

      // R10: reserved enable bits do nothing
      en_reg = 8'hD0; pri_reg = 8'hD0;
      tmr0_req = 1; misc_req = 1; tmr1_req = 1; ser_a_req = 1; ser_b_req = 1;
      expect_quiet(5, "R10 reserved enables");
      clear_reqs();

      // R5: either serial unit
      en_reg = 8'hA0; pri_reg = 8'h00;
      ser_b_req = 1;
      expect_vec(16'h002B, "R5 second serial unit");
      clear_reqs(); do_ack(1'b0); do_reti();
      ser_a_req = 1;
      expect_vec(16'h002B, "R5 first serial unit");
      clear_reqs(); do_ack(1'b0); do_reti();

      // R7 / R8: preemption and return
      en_reg = 8'hBF; pri_reg = 8'h06;
      tmr1_req = 1;
      expect_vec(16'h001B, "R7 low-level entry");
      do_ack(1'b0);
      tmr0_req = 1;
      expect_vec(16'h000B, "R7 high preempts low");
      do_ack(1'b1);
      tmr0_req = 0; misc_req = 1;
      expect_quiet(5, "R7 nothing preempts high");
      do_reti();
      expect_vec(16'h0013, "R8 pop high leaves low");
      misc_req = 0;
      do_ack(1'b1);
      do_reti();
      expect_quiet(5, "R7 same level waits (R8)");
      do_reti();
      expect_vec(16'h001B, "R8 pop low releases");
      tmr1_req = 0;
      do_ack(1'b0);
      do_reti();

      // randomized mix checked against the model
      for (int it = 0; it < 400; it++) begin
         int e;
         logic [4:0] rawv;
         en_reg  = 8'($urandom);
         if (($urandom % 4) != 0) en_reg[7] = 1'b1;
         pri_reg = 8'($urandom);
         {ser_b_req, ser_a_req, tmr1_req, misc_req, tmr0_req} = 5'($urandom);
         rawv = {ser_a_req | ser_b_req, tmr1_req, misc_req, tmr0_req, 1'b0};
         e = exp_idx(en_reg, pri_reg, rawv, m_hi, m_lo);
         @(negedge clk);
         check(irq_req == (e >= 0), "R2,R3,R4,R5,R7,R10 request",
               {31'b0, irq_req}, {31'b0, e >= 0});
         if (irq_req && e >= 0) begin
            bit lvl;
            logic [15:0] held;
            check(irq_vec == exp_vec(e), "R1,R2,R4 winner vector",
                  {16'b0, irq_vec}, {16'b0, exp_vec(e)});
            lvl  = pri_reg[slot(e)];
            held = irq_vec;
            en_reg  = 8'($urandom);
            pri_reg = 8'($urandom);
            {ser_b_req, ser_a_req, tmr1_req, misc_req, tmr0_req} = 5'($urandom);
            @(negedge clk);
            check(irq_req && irq_vec == held, "R9 hold until ack",
                  {15'b0, irq_req, irq_vec}, {15'b0, 1'b1, held});
            clear_reqs();
            do_ack(lvl);
            check(!irq_req, "R9 drop after ack", {31'b0, irq_req}, 32'd0);
         end else begin
            clear_reqs();
         end
         if (($urandom % 2) == 0 && (m_hi || m_lo)) do_reti();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule